// File: doc/BRIEF.md
# Clock Output Enable, Suspend and Shutdown Controller

This block decides, cycle by cycle, which clock outputs of a multi-PLL clock generator drive their pads and which internal clock domains (the PLL domains and the reference oscillator) keep running. It has two active-low control pins. The first always three-states every output when low. If the shutdown flag is set, the same low also powers down the domains and the oscillator. The second pin either suspends a programmed set of outputs and PLL domains or, when suspend mode is off, passes through unchanged as frequency-select bit 2.

The configuration gives a source code for each output: 0 is the reference and k is PLL domain k-1. The suspend mask is checked against these sources. Any output fed by a suspended PLL is added to the effective output mask, and a flag reports the addition. A domain that restarts must wait a programmable lock time before its outputs are enabled again. Every output enable changes only while that output's clock level is low, so no runt pulse reaches a pad. A domain or the oscillator is kept running until the last enabled output that depends on it has turned off cleanly.

Top module: `clkpwr_ctl`

## Requirements
- R1: While rst is high, at the following clock edge out_en, dom_en and osc_en all become zero.
- R2: While oe_n is low, every output whose clk_lvl bit is low at an edge has its out_en bit cleared at that edge.
- R3: With cfg_shdn_en=1 and oe_n low, a domain or the oscillator turns off at the first edge where no enabled output depends on it. With cfg_shdn_en=0, oe_n has no effect on dom_en or osc_en.
- R4: With cfg_susp_mode=1 and susp_n low, the outputs in the effective mask are disabled (subject to R8) and the domains set in cfg_dom_mask stop (subject to R6). With susp_n high or cfg_susp_mode=0, nothing is suspended.
- R5: The effective output mask is cfg_out_mask plus every output whose 2-bit source code (0 = reference, k = PLL domain k-1) names a domain set in cfg_dom_mask. mask_fixed is high in the same cycle exactly when this adds at least one bit.
- R6: A domain's dom_en stays high while any output that takes its clock from that domain is still enabled.
- R7: When a domain starts, or restarts after being stopped, its outputs can be enabled no earlier than L+1 edges after the start. L is cfg_lock_len, or 750000 cycles (3 ms at 250 MHz) when cfg_lock_len is 0.
- R8: An out_en bit changes only at an edge where that output's clk_lvl bit is low. At other edges it holds its value.
- R9: sel_bit2 equals susp_n when cfg_susp_mode=0 and is 0 when cfg_susp_mode=1, in the same cycle.
- R10: An output with source code 0 is enabled only while osc_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable / shutdown pin |
| susp_n | input | 1 | Active-low suspend pin, or select bit 2 |
| clk_lvl | input | N_OUT | Current level of each output clock |
| cfg_shdn_en | input | 1 | oe_n low also powers down the chip |
| cfg_susp_mode | input | 1 | susp_n acts as a suspend control |
| cfg_out_mask | input | N_OUT | Outputs to suspend |
| cfg_dom_mask | input | N_DOM | PLL domains to suspend |
| cfg_out_src | input | N_OUT*SRC_W | Source code per output (0 ref, k PLL k-1) |
| cfg_lock_len | input | LEN_W | Lock wait in cycles; 0 selects the default |
| out_en | output | N_OUT | Drive enable per output (0 = three-state) |
| dom_en | output | N_DOM | Run enable per PLL domain |
| osc_en | output | 1 | Reference oscillator enable |
| sel_bit2 | output | 1 | Select bit 2 passed on to frequency selection |
| mask_fixed | output | 1 | The suspend mask was extended for dependencies |

## Verification
mask_fixed and sel_bit2 are combinational and are checked in the same cycle as their inputs. out_en, dom_en and osc_en are due one edge after the conditions that set them. An output on a PLL first rises L+1 edges after its domain's dom_en rises, and later still if its clock level is high. The bench drives inputs at the falling edge, steps its own reference model of the requirements once per rising edge, and compares all outputs at the next falling edge. Directed cases count the exact edge on which the lock wait ends.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;
    localparam int CP_NUM_OUT   = 6;
    localparam int CP_NUM_DOM   = 3;
    localparam int CP_LEN_W     = 20;
    localparam int CP_LOCK_DFLT = 750000;

    typedef struct packed {
        logic shdn;   // full power-down requested
        logic susp;   // suspend requested
    } pwr_req_t;

    function automatic pwr_req_t pwr_decode(input logic shdn_en, input logic oe_n,
                                            input logic susp_mode, input logic susp_n);
        pwr_req_t r;
        r.shdn = shdn_en & ~oe_n;
        r.susp = susp_mode & ~susp_n;
        return r;
    endfunction
endpackage

// File: rtl/clkpwr_mask.sv
module clkpwr_mask #(
    parameter int N_OUT = 6,
    parameter int N_DOM = 3,
    parameter int SRC_W = 2
) (
    input  logic [N_OUT-1:0]       out_mask,
    input  logic [N_DOM-1:0]       dom_mask,
    input  logic [N_OUT*SRC_W-1:0] out_src,
    output logic [N_OUT-1:0]       eff_mask,
    output logic                   fixed
);
    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            eff_mask[o] = out_mask[o];
            for (int d = 0; d < N_DOM; d++) begin
                if (out_src[o*SRC_W +: SRC_W] == SRC_W'(d + 1) && dom_mask[d])
                    eff_mask[o] = 1'b1;
            end
        end
        fixed = |(eff_mask & ~out_mask);
    end
endmodule

// File: rtl/clkpwr_dom.sv
module clkpwr_dom #(
    parameter int LEN_W     = 20,
    parameter int LOCK_DFLT = 750000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hold,
    input  logic [LEN_W-1:0] len,
    output logic             en,
    output logic             locked
);
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] load;

    assign load   = (len == '0) ? LEN_W'(LOCK_DFLT) : len;
    assign locked = en & run & (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= 1'b0;
            cnt <= '0;
        end else begin
            en <= run | (en & hold);
            if (!run || !en)
                cnt <= load;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    AST_LOCK_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> !locked);  // R7
    AST_DOM_STOP: assert property (@(posedge clk) disable iff (rst)
        (!run && !hold) |=> !en);  // R3
endmodule

// File: rtl/clkpwr_gate.sv
module clkpwr_gate (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic want,
    output logic en
);
    always_ff @(posedge clk) begin
        if (rst)
            en <= 1'b0;
        else if (!lvl)
            en <= want;
    end

    AST_EDGE_LOW: assert property (@(posedge clk) disable iff (rst)
        (en != $past(en)) |-> !$past(lvl));  // R8
endmodule

// File: rtl/clkpwr_ctl.sv
module clkpwr_ctl
    import clkpwr_pkg::*;
#(
    parameter int N_OUT     = CP_NUM_OUT,
    parameter int N_DOM     = CP_NUM_DOM,
    parameter int LEN_W     = CP_LEN_W,
    parameter int LOCK_DFLT = CP_LOCK_DFLT,
    localparam int SRC_W    = $clog2(N_DOM + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   oe_n,
    input  logic                   susp_n,
    input  logic [N_OUT-1:0]       clk_lvl,
    input  logic                   cfg_shdn_en,
    input  logic                   cfg_susp_mode,
    input  logic [N_OUT-1:0]       cfg_out_mask,
    input  logic [N_DOM-1:0]       cfg_dom_mask,
    input  logic [N_OUT*SRC_W-1:0] cfg_out_src,
    input  logic [LEN_W-1:0]       cfg_lock_len,
    output logic [N_OUT-1:0]       out_en,
    output logic [N_DOM-1:0]       dom_en,
    output logic                   osc_en,
    output logic                   sel_bit2,
    output logic                   mask_fixed
);
    pwr_req_t                     req;
    logic [N_OUT-1:0]             eff_mask;
    logic [N_DOM-1:0]             run;
    logic [N_DOM-1:0]             hold;
    logic [N_DOM-1:0]             dom_lock;
    logic [N_DOM-1:0][N_OUT-1:0]  on_dom;
    logic [N_OUT-1:0]             ready;
    logic [N_OUT-1:0]             want;

    assign req      = pwr_decode(cfg_shdn_en, oe_n, cfg_susp_mode, susp_n);
    assign sel_bit2 = cfg_susp_mode ? 1'b0 : susp_n;

    clkpwr_mask #(.N_OUT(N_OUT), .N_DOM(N_DOM), .SRC_W(SRC_W)) u_mask (
        .out_mask (cfg_out_mask),
        .dom_mask (cfg_dom_mask),
        .out_src  (cfg_out_src),
        .eff_mask (eff_mask),
        .fixed    (mask_fixed)
    );

    always_comb begin
        for (int d = 0; d < N_DOM; d++)
            for (int o = 0; o < N_OUT; o++)
                on_dom[d][o] = (cfg_out_src[o*SRC_W +: SRC_W] == SRC_W'(d + 1));
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            ready[o] = (cfg_out_src[o*SRC_W +: SRC_W] == '0) ? osc_en : 1'b0;
            for (int d = 0; d < N_DOM; d++)
                if (on_dom[d][o])
                    ready[o] = dom_lock[d];
            want[o] = oe_n & ~(req.susp & eff_mask[o]) & ready[o];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            osc_en <= 1'b0;
        else
            osc_en <= ~req.shdn | (osc_en & (|out_en));
    end

    generate
        for (genvar d = 0; d < N_DOM; d++) begin : g_dom
            assign run[d]  = ~req.shdn & ~(req.susp & cfg_dom_mask[d]);
            assign hold[d] = |(out_en & on_dom[d]);

            clkpwr_dom #(.LEN_W(LEN_W), .LOCK_DFLT(LOCK_DFLT)) u_dom (
                .clk    (clk),
                .rst    (rst),
                .run    (run[d]),
                .hold   (hold[d]),
                .len    (cfg_lock_len),
                .en     (dom_en[d]),
                .locked (dom_lock[d])
            );

            AST_DOM_HELD: assert property (@(posedge clk) disable iff (rst)
                hold[d] |-> dom_en[d]);  // R6
        end

        for (genvar o = 0; o < N_OUT; o++) begin : g_out
            clkpwr_gate u_gate (
                .clk  (clk),
                .rst  (rst),
                .lvl  (clk_lvl[o]),
                .want (want[o]),
                .en   (out_en[o])
            );

            AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
                (!$past(oe_n) && !$past(clk_lvl[o])) |-> !out_en[o]);  // R2
        end
    endgenerate

    AST_OSC_QUIET: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (out_en == '0));  // R3
endmodule

// File: tb/sim_clkpwr_ctl.sv
`timescale 1ns/1ps
module sim_clkpwr_ctl;
    localparam int NO = 6;
    localparam int ND = 3;
    localparam int LW = 20;
    localparam int DFLT = 750000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic oe_n = 1'b1, susp_n = 1'b1;
    logic [NO-1:0] clk_lvl = '0;
    logic shdn_en = 1'b0, susp_mode = 1'b0;
    logic [NO-1:0] out_mask = '0;
    logic [ND-1:0] dom_mask = '0;
    logic [2*NO-1:0] out_src = '0;
    logic [LW-1:0] lock_len = LW'(4);
    logic [NO-1:0] out_en;
    logic [ND-1:0] dom_en;
    logic osc_en, sel_bit2, mask_fixed;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    clkpwr_ctl u0 (
        .clk(clk), .rst(rst), .oe_n(oe_n), .susp_n(susp_n), .clk_lvl(clk_lvl),
        .cfg_shdn_en(shdn_en), .cfg_susp_mode(susp_mode), .cfg_out_mask(out_mask),
        .cfg_dom_mask(dom_mask), .cfg_out_src(out_src), .cfg_lock_len(lock_len),
        .out_en(out_en), .dom_en(dom_en), .osc_en(osc_en), .sel_bit2(sel_bit2),
        .mask_fixed(mask_fixed)
    );

    // reference model state
    logic [NO-1:0] m_out = '0;
    logic [ND-1:0] m_dom = '0;
    logic          m_osc = 1'b0;
    int            m_cnt [ND];

    function automatic int src_of(int o);
        return int'(out_src[2*o +: 2]);
    endfunction

    function automatic logic [NO-1:0] exp_eff();
        logic [NO-1:0] e = out_mask;
        for (int o = 0; o < NO; o++)
            if (src_of(o) != 0 && dom_mask[src_of(o)-1]) e[o] = 1'b1;
        return e;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic sd, sp;
        logic [NO-1:0] eff, nxt_out;
        logic [ND-1:0] run, lock, hold, nxt_dom;
        int load;
        if (rst) begin
            m_out = '0; m_dom = '0; m_osc = 1'b0;
            for (int d = 0; d < ND; d++) m_cnt[d] = 0;
            return;
        end
        sd   = shdn_en & ~oe_n;
        sp   = susp_mode & ~susp_n;
        eff  = exp_eff();
        load = (lock_len == 0) ? DFLT : int'(lock_len);
        for (int d = 0; d < ND; d++) begin
            run[d]  = ~sd & ~(sp & dom_mask[d]);
            lock[d] = m_dom[d] & run[d] & (m_cnt[d] == 0);
            hold[d] = 1'b0;
            for (int o = 0; o < NO; o++)
                if (src_of(o) == d + 1 && m_out[o]) hold[d] = 1'b1;
            nxt_dom[d] = run[d] | (m_dom[d] & hold[d]);
        end
        for (int o = 0; o < NO; o++) begin
            logic rdy;
            rdy = (src_of(o) == 0) ? m_osc : lock[src_of(o)-1];
            nxt_out[o] = clk_lvl[o] ? m_out[o] : (oe_n & ~(sp & eff[o]) & rdy);
        end
        for (int d = 0; d < ND; d++) begin
            if (!run[d] || !m_dom[d]) m_cnt[d] = load;
            else if (m_cnt[d] != 0) m_cnt[d] = m_cnt[d] - 1;
        end
        m_osc = ~sd | (m_osc & (|m_out));
        m_out = nxt_out;
        m_dom = nxt_dom;
    endtask

    task automatic compare();
        check("R2,R4,R8,R10 out_en", int'(out_en), int'(m_out));
        check("R3,R4,R6 dom_en", int'(dom_en), int'(m_dom));
        check("R3 osc_en", int'(osc_en), int'(m_osc));
        check("R5 mask_fixed", int'(mask_fixed), int'(|(exp_eff() & ~out_mask)));
        check("R9 sel_bit2", int'(sel_bit2), int'(susp_mode ? 1'b0 : susp_n));
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) cyc();
        check("R1 reset out_en", int'(out_en), 0);
        check("R1 reset dom_en", int'(dom_en), 0);
        check("R1 reset osc_en", int'(osc_en), 0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k;
        void'($urandom(32'd20240611));
        @(negedge clk);

        // directed: exact lock wait, all outputs on PLL domain 0
        out_src = {NO{2'd1}};
        lock_len = LW'(5);
        do_reset();
        k = 0;
        for (int i = 0; i < 50; i++) begin
            cyc();
            k++;
            if (out_en[0]) break;
        end
        check("R7 lock wait edges", k, 5 + 2);

        // directed: mask extension flag
        dom_mask = 3'b001; out_mask = '0;
        #1 check("R5 fixed when extended", int'(mask_fixed), 1);
        out_mask = '1;
        #1 check("R5 no fix when covered", int'(mask_fixed), 0);
        dom_mask = '0; out_mask = '0;

        // directed: select bit passthrough
        susp_mode = 1'b0; susp_n = 1'b0;
        #1 check("R9 pass low", int'(sel_bit2), 0);
        susp_n = 1'b1;
        #1 check("R9 pass high", int'(sel_bit2), 1);
        susp_mode = 1'b1;
        #1 check("R9 blocked in suspend mode", int'(sel_bit2), 0);
        susp_mode = 1'b0;
        @(negedge clk);

        // directed: OE-only mode keeps domains running
        shdn_en = 1'b0; oe_n = 1'b0;
        repeat (4) cyc();
        check("R3 oe-only dom_en", int'(dom_en), 7);
        check("R2 oe low out_en", int'(out_en), 0);
        oe_n = 1'b1;

        // directed: zero length selects the long default
        lock_len = '0;
        do_reset();
        repeat (1000) cyc();
        check("R7 default wait dom_en", int'(dom_en[0]), 1);
        check("R7 default wait out_en", int'(out_en[0]), 0);

        // random scenarios
        for (int s = 0; s < 10; s++) begin
            for (int o = 0; o < NO; o++) out_src[2*o +: 2] = 2'($urandom % 4);
            out_mask  = NO'($urandom);
            dom_mask  = ND'($urandom);
            shdn_en   = 1'($urandom);
            susp_mode = 1'($urandom);
            lock_len  = LW'(2 + $urandom % 10);
            oe_n = 1'b1; susp_n = 1'b1;
            do_reset();
            for (int c = 0; c < 500; c++) begin
                clk_lvl = NO'($urandom);
                if ($urandom % 40 == 0) oe_n = ~oe_n;
                if ($urandom % 40 == 0) susp_n = ~susp_n;
                if ($urandom % 120 == 0) begin
                    out_mask = NO'($urandom);
                    dom_mask = ND'($urandom);
                    shdn_en  = 1'($urandom);
                    susp_mode = 1'($urandom);
                end
                cyc();
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule